// File: doc/BRIEF.md
# USB Downstream Port Attach and Detach Qualifier

This block observes the two single-ended line bits of one USB downstream port and decides when a device has really been plugged in or pulled out. A device is treated as present only after its idle line state has held for a full connect window. It is treated as gone only after both lines have sat at zero (SE0) for a full detach window. Short glitches therefore never become events. The line that is pulled high at attach gives the speed class: D+ high means full or high speed, and D− high means low speed.

Time is counted in ticks of a fixed-rate enable, not in clock cycles. With the default limits and a tick on every cycle of a 48 MHz clock, the connect window is 120 ticks (2.5 µs). This is the shortest time allowed, and it is far inside the 2000 µs ceiling. The detach window is 108 ticks (2.25 µs), which sits between the 2.0 µs and 2.5 µs bounds. The outputs are a level pair (connected, low speed) and two one-cycle change pulses that a status register can latch.

Top module: `usb_attach_detect`

## Requirements
- R1: When disconnected, CONN_TICKS consecutive ticks of the J-type attach state (dp=1, dm=0) set `connected` to 1 with `low_speed`=0. The change takes effect at the clock edge of the last of those ticks.
- R2: When disconnected, CONN_TICKS consecutive ticks of the K-type attach state (dp=0, dm=1) set `connected` to 1 with `low_speed`=1.
- R3: Any change of the sampled line state during the connect window restarts it. This includes a change between the two attach states and a change to SE0 or SE1. A new attach state counts as tick 1.
- R4: The SE1 state (dp=1, dm=1) never counts toward a connect, however long it lasts.
- R5: When connected, DISC_TICKS consecutive ticks of SE0 (dp=0, dm=0) clear `connected` and `low_speed`.
- R6: When connected, any tick whose line state is not SE0 clears the detach count. This includes SE1. The next SE0 tick counts as tick 1.
- R7: `low_speed` is captured only at the moment of connect. It does not change with the line state while the port stays connected.
- R8: `conn_chg` is high for exactly one cycle per qualified connect, and `disc_chg` is high for exactly one cycle per qualified detach. While the port stays in a state, further line activity gives no repeat pulse.
- R9: Cycles with `tick`=0 neither advance nor clear either window, and the line state in those cycles is not sampled.
- R10: A synchronous active-high `rst` forces the port to disconnected, with `low_speed`=0, no pulses and both windows cleared. The line state is taken as SE0 at reset.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base enable; one window count per tick |
| dp | input | 1 | Synchronised single-ended D+ level |
| dm | input | 1 | Synchronised single-ended D− level |
| connected | output | 1 | Device present |
| low_speed | output | 1 | Attached device is low speed; valid while connected |
| conn_chg | output | 1 | One-cycle pulse on a qualified connect |
| disc_chg | output | 1 | One-cycle pulse on a qualified detach |

## Verification
The bench builds the block with CONN_TICKS=6 and DISC_TICKS=4. Windows this short let each restart case be shown in only a few cycles. These cases are a J to K swap, an SE0 glitch, an SE1 glitch during detach, and SE1 before attach. Because the connect and detach limits differ, a count that is not reset, or that uses the wrong limit, gives an edge at the wrong cycle. The tick-gating test spreads a connect across idle cycles, so the bench can confirm that the count is held and not cleared during cycles with no tick.

// File: rtl/usbpd_pkg.sv
package usbpd_pkg;

  // Sampled line state, encoded as {dp, dm}
  typedef enum logic [1:0] {
    LN_SE0   = 2'b00,
    LN_KLOW  = 2'b01,
    LN_JFULL = 2'b10,
    LN_SE1   = 2'b11
  } line_t;

  function automatic line_t classify(input logic dp, input logic dm);
    return line_t'({dp, dm});
  endfunction

  function automatic logic is_attach(input line_t s);
    return (s == LN_KLOW) || (s == LN_JFULL);
  endfunction

endpackage

// File: rtl/att_line_sampler.sv
module att_line_sampler
  import usbpd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  dp,
  input  logic  dm,
  output line_t now_st,
  output line_t prev_st
);

  assign now_st = classify(dp, dm);

  // Line state seen at the previous tick; the bus is taken as idle SE0 at reset
  always_ff @(posedge clk) begin
    if (rst)       prev_st <= LN_SE0;
    else if (tick) prev_st <= now_st;
  end

  // R9: the stored state moves only on a tick
  assert_prev_only_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(prev_st));

endmodule

// File: rtl/att_window_qual.sv
module att_window_qual #(
  parameter int unsigned LIMIT = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic enable,
  input  logic start,
  input  logic step,
  output logic hit
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_adv;

  // Count after this tick: continue the run, begin a new one, or drop it
  function automatic logic [CW-1:0] advance(input logic [CW-1:0] c,
                                            input logic st, input logic sp);
    if (sp) return c + 1'b1;
    if (st) return CW'(1);
    return '0;
  endfunction

  assign cnt_adv = advance(cnt, start, step);
  assign hit     = enable && tick && (cnt_adv == LIM_C);

  always_ff @(posedge clk) begin
    if (rst || !enable) cnt <= '0;
    else if (tick)      cnt <= hit ? '0 : cnt_adv;
  end

  // R3 / R6: the count never reaches the limit without firing and clearing
  assert_cnt_below_limit_R3: assert property (@(posedge clk) disable iff (rst)
    cnt < LIM_C);

  // R9: an enabled window holds its count through cycles with no tick
  assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (rst)
    (enable && !tick) |=> (!enable || $stable(cnt)));

  // R6: a tick that neither starts nor continues a run leaves the count at zero
  assert_break_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && tick && !start && !step) |=> (cnt == '0));

endmodule

// File: rtl/att_port_fsm.sv
module att_port_fsm
  import usbpd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  conn_hit,
  input  logic  disc_hit,
  input  line_t now_st,
  output logic  connected,
  output logic  low_speed,
  output logic  conn_chg,
  output logic  disc_chg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      connected <= 1'b0;
      low_speed <= 1'b0;
      conn_chg  <= 1'b0;
      disc_chg  <= 1'b0;
    end else begin
      conn_chg <= 1'b0;
      disc_chg <= 1'b0;
      if (!connected && conn_hit) begin
        connected <= 1'b1;
        low_speed <= (now_st == LN_KLOW);
        conn_chg  <= 1'b1;
      end else if (connected && disc_hit) begin
        connected <= 1'b0;
        low_speed <= 1'b0;
        disc_chg  <= 1'b1;
      end
    end
  end

  // R8: every rise of connected comes with exactly one connect pulse
  assert_conn_pulse_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (connected && !$past(connected)) |-> conn_chg);

  // R8: a detach pulse only follows a connected cycle and leaves the port idle
  assert_disc_pulse_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    disc_chg |-> (!connected && $past(connected)));

  // R8: both pulses can never be high in the same cycle
  assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(conn_chg && disc_chg));

  // R7: low_speed is meaningful only while connected and is frozen meanwhile
  assert_ls_needs_conn_R7: assert property (@(posedge clk) disable iff (rst)
    low_speed |-> connected);
  assert_ls_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (connected && $past(connected)) |-> (low_speed == $past(low_speed)));

  // R4: a connect is never taken on an SE1 line state
  assert_no_se1_attach_R4: assert property (@(posedge clk) disable iff (rst)
    (!connected && conn_hit) |-> (now_st != LN_SE1));

endmodule

// File: rtl/usb_attach_detect.sv
module usb_attach_detect
  import usbpd_pkg::*;
#(
  parameter int unsigned CONN_TICKS = 120,
  parameter int unsigned DISC_TICKS = 108
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic dp,
  input  logic dm,
  output logic connected,
  output logic low_speed,
  output logic conn_chg,
  output logic disc_chg
);

  line_t now_st;
  line_t prev_st;
  logic  same_st;
  logic  attach_now;
  logic  se0_now;
  logic  se0_prev;
  logic  conn_hit;
  logic  disc_hit;

  att_line_sampler u_sampler (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .dp      (dp),
    .dm      (dm),
    .now_st  (now_st),
    .prev_st (prev_st)
  );

  assign same_st    = (now_st == prev_st);
  assign attach_now = is_attach(now_st);
  assign se0_now    = (now_st == LN_SE0);
  assign se0_prev   = (prev_st == LN_SE0);

  // Connect window: one attach state held unchanged
  att_window_qual #(.LIMIT(CONN_TICKS)) u_conn_win (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .enable (!connected),
    .start  (attach_now && !same_st),
    .step   (attach_now && same_st),
    .hit    (conn_hit)
  );

  // Detach window: SE0 held without a break
  att_window_qual #(.LIMIT(DISC_TICKS)) u_disc_win (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .enable (connected),
    .start  (se0_now && !se0_prev),
    .step   (se0_now && se0_prev),
    .hit    (disc_hit)
  );

  att_port_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .conn_hit  (conn_hit),
    .disc_hit  (disc_hit),
    .now_st    (now_st),
    .connected (connected),
    .low_speed (low_speed),
    .conn_chg  (conn_chg),
    .disc_chg  (disc_chg)
  );

  // R10: reset leaves the port idle with no pulse
  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!connected && !low_speed && !conn_chg && !disc_chg));

  // R1 / R5: a window fires only in the phase that owns it
  assert_hits_phase_R1: assert property (@(posedge clk) disable iff (rst)
    !(conn_hit && connected) && !(disc_hit && !connected));

endmodule

// File: tb/test_usb_attach_detect.sv
module test_usb_attach_detect;

  localparam int CONN = 6;
  localparam int DISC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic dp = 1'b0;
  logic dm = 1'b0;
  logic connected, low_speed, conn_chg, disc_chg;

  always #5 clk = ~clk;

  usb_attach_detect #(.CONN_TICKS(CONN), .DISC_TICKS(DISC)) i_usb_attach_detect (
    .clk(clk), .rst(rst), .tick(tick), .dp(dp), .dm(dm),
    .connected(connected), .low_speed(low_speed),
    .conn_chg(conn_chg), .disc_chg(disc_chg)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int n_conn   = 0;
  int n_disc   = 0;
  bit finished = 1'b0;

  // Pulse tally, sampled shortly after each edge
  always @(posedge clk) begin
    #2;
    if (conn_chg === 1'b1) n_conn++;
    if (disc_chg === 1'b1) n_disc++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Must be called at a falling edge; leaves time at a falling edge
  task automatic apply(input logic p, input logic m, input int cycles);
    dp = p;
    dm = m;
    repeat (cycles) @(negedge clk);
  endtask

  // Row: line state, cycles held, expected connected, low_speed, total pulses
  typedef struct packed {
    logic       dp;
    logic       dm;
    logic [7:0] cyc;
    logic       conn;
    logic       ls;
    logic [3:0] nc;
    logic [3:0] nd;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [19] = '{
    '{1'b0, 1'b0, 8'd10, 1'b0, 1'b0, 4'd0, 4'd0, 4'd10}, // R10 idle after reset
    '{1'b1, 1'b0, 8'd5,  1'b0, 1'b0, 4'd0, 4'd0, 4'd1},  // R1 one tick short
    '{1'b1, 1'b0, 8'd1,  1'b1, 1'b0, 4'd1, 4'd0, 4'd1},  // R1 full window
    '{1'b0, 1'b0, 8'd3,  1'b1, 1'b0, 4'd1, 4'd0, 4'd5},  // R5 partial SE0
    '{1'b1, 1'b0, 8'd2,  1'b1, 1'b0, 4'd1, 4'd0, 4'd6},  // R6 J glitch breaks it
    '{1'b0, 1'b0, 8'd3,  1'b1, 1'b0, 4'd1, 4'd0, 4'd6},  // R6 count restarted
    '{1'b1, 1'b1, 8'd1,  1'b1, 1'b0, 4'd1, 4'd0, 4'd6},  // R6 SE1 breaks it
    '{1'b0, 1'b0, 8'd4,  1'b0, 1'b0, 4'd1, 4'd1, 4'd5},  // R5 full detach
    '{1'b0, 1'b1, 8'd3,  1'b0, 1'b0, 4'd1, 4'd1, 4'd3},  // R3 K partial
    '{1'b1, 1'b0, 8'd3,  1'b0, 1'b0, 4'd1, 4'd1, 4'd3},  // R3 K->J restarts
    '{1'b0, 1'b1, 8'd5,  1'b0, 1'b0, 4'd1, 4'd1, 4'd3},  // R3 J->K restarts
    '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 4'd2, 4'd1, 4'd2},  // R2 low-speed connect
    '{1'b0, 1'b1, 8'd20, 1'b1, 1'b1, 4'd2, 4'd1, 4'd8},  // R8 no repeat connect
    '{1'b1, 1'b0, 8'd10, 1'b1, 1'b1, 4'd2, 4'd1, 4'd7},  // R7 J while connected
    '{1'b1, 1'b1, 8'd30, 1'b1, 1'b1, 4'd2, 4'd1, 4'd7},  // R7 SE1 while connected
    '{1'b0, 1'b0, 8'd4,  1'b0, 1'b0, 4'd2, 4'd2, 4'd5},  // R5 detach clears ls
    '{1'b0, 1'b0, 8'd20, 1'b0, 1'b0, 4'd2, 4'd2, 4'd8},  // R8 no repeat detach
    '{1'b1, 1'b1, 8'd30, 1'b0, 1'b0, 4'd2, 4'd2, 4'd4},  // R4 SE1 never attaches
    '{1'b1, 1'b0, 8'd6,  1'b1, 1'b0, 4'd3, 4'd2, 4'd3}   // R3 SE1->J starts at 1
  };

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10", "connected in reset", int'(connected), 0);
    check("R10", "low_speed in reset", int'(low_speed), 0);
    rst = 1'b0;

    foreach (VECS[i]) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VECS[i].req, i);
      apply(VECS[i].dp, VECS[i].dm, int'(VECS[i].cyc));
      check(tag, "connected", int'(connected), int'(VECS[i].conn));
      check(tag, "low_speed", int'(low_speed), int'(VECS[i].ls));
      check(tag, "connect pulses", n_conn, int'(VECS[i].nc));
      check(tag, "detach pulses", n_disc, int'(VECS[i].nd));
    end

    // R10: reset while connected, lines still J
    rst = 1'b1;
    apply(1'b1, 1'b0, 3);
    check("R10", "connected after reset", int'(connected), 0);
    check("R10", "low_speed after reset", int'(low_speed), 0);
    check("R10", "no pulse from reset", n_conn * 16 + n_disc, 3 * 16 + 2);
    rst = 1'b0;

    // R9: ticks spread out; only five ticks in ten cycles
    for (int k = 0; k < 5; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
    check("R9", "five ticks not enough", int'(connected), 0);
    // R9: the line drops to SE0 in cycles with no tick; nothing is sampled or cleared
    apply(1'b0, 1'b0, 20);
    check("R9", "idle cycles hold count", int'(connected), 0);
    dp = 1'b1;
    dm = 1'b0;
    tick = 1'b1;
    @(negedge clk);
    check("R9", "sixth tick connects", int'(connected), 1);
    check("R8", "conn_chg high on edge", int'(conn_chg), 1);
    @(negedge clk);
    check("R8", "conn_chg one cycle", int'(conn_chg), 0);
    check("R8", "connect pulse total", n_conn, 4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule